// File: doc/BRIEF.md
# Four-Port Shared Byte Memory with Write Block

A synchronous byte-wide memory that four agents share without a bus between them. Each port has its own address, write data, read data and controls, and every port reaches every byte of the array. In a given clock cycle all four ports may read or write at once, each independently of the others. A typical use is a mailbox or work buffer between several processors, or a sample store that feeds two operand streams of a multiply-accumulate engine while a third port collects the results and a fourth loads data and coefficients.

Each port carries an active-low hold input that suppresses that port's writes while leaving its reads alone. External arbitration uses it to keep a writer off the array without stalling that writer's reads. Simultaneous accesses to one address are resolved deterministically, and they are also reported. When several ports write the same byte in one cycle, each writer receives a pulse. When a port reads a byte that another port is writing in the same cycle, the reader receives a pulse.

Top module: `quad_port_ram`

## Requirements
- R1: The array holds 2^AW bytes (AW=11 by default, giving 2048), and every port can write or read every address, including the top address 2^AW-1. A byte written through one port is read back unchanged through any other port.
- R2: All four ports act in the same cycle. Writes from several ports to distinct addresses are all stored, and reads from several ports all return their own bytes.
- R3: A port writes on a rising edge where ce_n=0, we_n=0 and busy_n=1. When busy_n=0, the write is dropped: the byte keeps its old value, and the port takes no part in collision flags.
- R4: busy_n has no effect on reads. A read with busy_n=0 returns the same data and drive flag as it would with busy_n=1.
- R5: A port reads on a rising edge where ce_n=0 and we_n=1. One cycle later, rd_drv=1 and rdata holds the byte if oe_n was 0 at that edge. If oe_n was 1, then rd_drv=0 and rdata=0.
- R6: With ce_n=1, a port neither writes nor reads, whatever its other inputs are. In the next cycle its rd_drv, rdata, wcoll and rcoll are 0.
- R7: When two or more effective writes target the same address in one cycle, wcoll goes to 1 in the next cycle for each of those ports and for no other port. The byte keeps the data of the lowest-numbered writer (WIN=QP_LOW_WINS, the default) or of the highest-numbered writer (QP_HIGH_WINS).
- R8: When a port reads an address that another port effectively writes in the same cycle, the reader's rcoll is 1 in the next cycle. Its rdata holds the byte's value from before the write, and the write completes.
- R9: The reset is synchronous and active high. After a reset cycle, rd_drv, rdata, wcoll and rcoll are all 0. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of output registers |
| ce_n | input | NP | Per-port enable, active low |
| we_n | input | NP | Per-port write select, 0 = write, 1 = read |
| oe_n | input | NP | Per-port read output enable, active low |
| busy_n | input | NP | Per-port write hold, 0 blocks writes |
| addr | input | NP x AW | Per-port byte address |
| wdata | input | NP x DW | Per-port write data |
| rdata | output | NP x DW | Per-port registered read data, 0 when not driven |
| rd_drv | output | NP | Per-port read data valid and driven |
| wcoll | output | NP | Per-port same-address write collision pulse |
| rcoll | output | NP | Per-port read-during-write pulse |

## Verification
The hardest case to reach is a cycle that combines several kinds of overlap on one byte: a two- or three-way write collision, a reader of that same byte, and a blocked writer aimed at it. In that cycle, priority, read-first data and the exclusion of blocked writers must all hold together. Directed cycles first build each of these combinations on purpose. A long random phase then confines all four ports to eight addresses with frequent holds, so these overlaps recur thousands of times. A behavioural byte model predicts every output on every clock.

// File: rtl/qp_pkg.sv
package qp_pkg;
  // Which writer keeps the byte when several ports write one address.
  typedef enum logic [0:0] {
    QP_LOW_WINS  = 1'b0,
    QP_HIGH_WINS = 1'b1
  } qp_win_e;
endpackage

// File: rtl/qp_port_decode.sv
module qp_port_decode #(
  parameter int NP = 4
) (
  input  logic [NP-1:0] ce_n,
  input  logic [NP-1:0] we_n,
  input  logic [NP-1:0] oe_n,
  input  logic [NP-1:0] busy_n,
  output logic [NP-1:0] wr_en,
  output logic [NP-1:0] rd_en,
  output logic [NP-1:0] rd_oe
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic sel;
    assign sel      = ~ce_n[p];
    // the hold input only gates the write path
    assign wr_en[p] = sel & ~we_n[p] & busy_n[p];
    assign rd_en[p] = sel &  we_n[p];
    assign rd_oe[p] = sel &  we_n[p] & ~oe_n[p];
  end
endmodule

// File: rtl/qp_collide.sv
module qp_collide #(
  parameter int NP = 4,
  parameter int AW = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          wr_en,
  input  logic [NP-1:0]          rd_en,
  input  logic [NP-1:0][AW-1:0]  addr,
  output logic [NP-1:0]          wcoll,
  output logic [NP-1:0]          rcoll
);
  logic [NP-1:0] hit;
  logic [NP-1:0] wcoll_d, rcoll_d;

  // hit[p]: some other port is effectively writing addr[p] this cycle
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      hit[p] = 1'b0;
      for (int q = 0; q < NP; q++) begin
        if (q != p && wr_en[q] && addr[q] == addr[p]) hit[p] = 1'b1;
      end
      wcoll_d[p] = wr_en[p] & hit[p];
      rcoll_d[p] = rd_en[p] & hit[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcoll <= '0;
      rcoll <= '0;
    end else begin
      wcoll <= wcoll_d;
      rcoll <= rcoll_d;
    end
  end

  // a write collision always involves at least two ports
  assert_pair_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(wcoll) != 1);

  for (genvar p = 0; p < NP; p++) begin : g_chk
    assert_rcoll_src_R8: assert property (@(posedge clk) disable iff (rst)
      rcoll[p] |-> $past(rd_en[p]) && !wcoll[p]);
    assert_wcoll_src_R7: assert property (@(posedge clk) disable iff (rst)
      wcoll[p] |-> $past(wr_en[p]));
  end
endmodule

// File: rtl/qp_array.sv
module qp_array
  import qp_pkg::*;
#(
  parameter int      NP  = 4,
  parameter int      AW  = 11,
  parameter int      DW  = 8,
  parameter qp_win_e WIN = QP_LOW_WINS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          wr_en,
  input  logic [NP-1:0]          rd_oe,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [NP-1:0][DW-1:0]  wdata,
  output logic [NP-1:0][DW-1:0]  rdata,
  output logic [NP-1:0]          rd_drv
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Later assignments in one block override earlier ones, so the loop
  // order sets the winner of a same-address write.
  if (WIN == QP_LOW_WINS) begin : g_low
    always_ff @(posedge clk) begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (wr_en[p]) mem[addr[p]] <= wdata[p];
      end
    end
  end else begin : g_high
    always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
        if (wr_en[p]) mem[addr[p]] <= wdata[p];
      end
    end
  end

  // read-first: the read sees the byte from before this edge's writes
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_drv <= '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        rd_drv[p] <= rd_oe[p];
        rdata[p]  <= rd_oe[p] ? mem[addr[p]] : '0;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !rd_drv[p] |-> rdata[p] == '0);
  end
endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
  import qp_pkg::*;
#(
  parameter int      NP  = 4,
  parameter int      AW  = 11,
  parameter int      DW  = 8,
  parameter qp_win_e WIN = QP_LOW_WINS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          ce_n,
  input  logic [NP-1:0]          we_n,
  input  logic [NP-1:0]          oe_n,
  input  logic [NP-1:0]          busy_n,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [NP-1:0][DW-1:0]  wdata,
  output logic [NP-1:0][DW-1:0]  rdata,
  output logic [NP-1:0]          rd_drv,
  output logic [NP-1:0]          wcoll,
  output logic [NP-1:0]          rcoll
);
  logic [NP-1:0] wr_en, rd_en, rd_oe;

  qp_port_decode #(.NP(NP)) u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy_n(busy_n),
    .wr_en(wr_en), .rd_en(rd_en), .rd_oe(rd_oe)
  );

  qp_collide #(.NP(NP), .AW(AW)) u_col (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wcoll(wcoll), .rcoll(rcoll)
  );

  qp_array #(.NP(NP), .AW(AW), .DW(DW), .WIN(WIN)) u_arr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_oe(rd_oe), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_drv(rd_drv)
  );

  for (genvar p = 0; p < NP; p++) begin : g_chk
    assert_blocked_R3: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && !we_n[p] && !busy_n[p]) |=> !wcoll[p] && !rd_drv[p]);
    assert_busy_read_R4: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && we_n[p] && !oe_n[p] && !busy_n[p]) |=> rd_drv[p]);
    assert_rd_latency_R5: assert property (@(posedge clk) disable iff (rst)
      (!ce_n[p] && we_n[p] && !oe_n[p]) |=> rd_drv[p]);
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
      ce_n[p] |=> !rd_drv[p] && !wcoll[p] && !rcoll[p]);
  end
endmodule

// File: tb/tb_quad_port_ram.sv
module tb_quad_port_ram;
  localparam int NP = 4;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] ce_n = '1, we_n = '1, oe_n = '1, busy_n = '1;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][DW-1:0] wdata = '0;
  logic [NP-1:0][DW-1:0] rdata;
  logic [NP-1:0] rd_drv, wcoll, rcoll;

  int errors = 0;
  int checks = 0;
  int mdl [DEPTH];
  int e_data [NP];
  int e_drv [NP];
  int e_wc [NP];
  int e_rc [NP];

  always #10 clk = ~clk;

  quad_port_ram #(.NP(NP), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .busy_n(busy_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rd_drv(rd_drv), .wcoll(wcoll), .rcoll(rcoll)
  );

  task automatic chk(string tag, string what, int p, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s port %0d %s actual=%0h expected=%0h", tag, p, what, act, exp);
    end
  endtask

  task automatic idle_all();
    ce_n = '1; we_n = '1; oe_n = '1; busy_n = '1;
  endtask

  task automatic set_wr(int p, int a, int d, bit blk = 0);
    ce_n[p] = 0; we_n[p] = 0; oe_n[p] = 1; busy_n[p] = !blk;
    addr[p] = AW'(a); wdata[p] = DW'(d);
  endtask

  task automatic set_rd(int p, int a, bit oe = 1, bit blk = 0);
    ce_n[p] = 0; we_n[p] = 1; oe_n[p] = !oe; busy_n[p] = !blk;
    addr[p] = AW'(a);
  endtask

  // Stimulus is already set (after a falling edge); predict, clock, compare.
  task automatic step(string tag);
    bit wr [NP];
    bit rd [NP];
    for (int p = 0; p < NP; p++) begin
      wr[p] = !ce_n[p] && !we_n[p] && busy_n[p];
      rd[p] = !ce_n[p] && we_n[p];
    end
    for (int p = 0; p < NP; p++) begin
      bit hit = 0;
      for (int q = 0; q < NP; q++)
        if (q != p && wr[q] && addr[q] == addr[p]) hit = 1;
      e_drv[p]  = rst ? 0 : int'(rd[p] && !oe_n[p]);
      e_data[p] = (e_drv[p] != 0) ? mdl[addr[p]] : 0;
      e_wc[p]   = rst ? 0 : int'(wr[p] && hit);
      e_rc[p]   = rst ? 0 : int'(rd[p] && hit);
    end
    for (int p = NP - 1; p >= 0; p--)
      if (wr[p]) mdl[addr[p]] = int'(wdata[p]);
    @(posedge clk);
    #2;
    for (int p = 0; p < NP; p++) begin
      chk(tag, "rd_drv", p, int'(rd_drv[p]), e_drv[p]);
      if (e_data[p] >= 0) chk(tag, "rdata", p, int'(rdata[p]), e_data[p]);
      chk(tag, "wcoll", p, int'(wcoll[p]), e_wc[p]);
      chk(tag, "rcoll", p, int'(rcoll[p]), e_rc[p]);
    end
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = -1;
    @(negedge clk);
    idle_all();
    set_rd(0, 0);
    step("R9");
    step("R9");
    rst = 0;
    // R1: extremes of the address space through different ports
    set_wr(0, 0, 8'h11); set_wr(3, DEPTH - 1, 8'hA5); step("R1");
    set_rd(1, DEPTH - 1); set_rd(2, 0); step("R1");
    // R2: four distinct writes then four crossed reads
    for (int p = 0; p < NP; p++) set_wr(p, p + 1, 8'h20 + p);
    step("R2");
    for (int p = 0; p < NP; p++) set_rd(p, NP - p);
    step("R2");
    for (int i = 5; i < 8; i++) begin set_wr(0, i, 8'h30 + i); step("R2"); end
    // R3: blocked write leaves byte intact, and joins no collision
    set_wr(2, 1, 8'hEE, 1); set_wr(1, 1, 8'h44); step("R3");
    set_rd(0, 1); step("R3");
    set_wr(3, 2, 8'h99, 1); step("R3");
    set_rd(3, 2); step("R3");
    // R4: read with hold asserted
    set_rd(2, 3, 1, 1); set_rd(1, 3); step("R4");
    // R5: read without output enable
    set_rd(0, 4, 0); set_rd(1, 4); step("R5");
    // R6: disabled port with write controls active
    set_wr(1, 5, 8'h77); ce_n[1] = 1; step("R6");
    set_rd(2, 5); step("R6");
    // R7: three-way collision, lowest writer keeps the byte
    set_wr(1, 6, 8'h61); set_wr(2, 6, 8'h62); set_wr(3, 6, 8'h63);
    set_rd(0, 0); step("R7");
    set_rd(0, 6); step("R7");
    // R8: read during another port's write returns old byte
    set_wr(0, 7, 8'h5C); set_rd(2, 7); set_rd(3, 7, 0); step("R8");
    set_rd(1, 7); step("R8");
    // R9: reset mid-run keeps array contents
    rst = 1; set_rd(0, 7); step("R9");
    rst = 0;
    set_rd(0, 7); set_rd(1, DEPTH - 1); step("R9");
    // R2: dense random traffic on eight addresses
    for (int i = 0; i < 8; i++) begin set_wr(i % NP, i, i * 17); step("R2"); end
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NP; p++) begin
        ce_n[p]   = ($urandom % 5) == 0;
        we_n[p]   = $urandom % 2;
        oe_n[p]   = ($urandom % 4) == 0;
        busy_n[p] = ($urandom % 4) != 0;
        addr[p]   = AW'($urandom % 8);
        wdata[p]  = DW'($urandom);
      end
      step("R2");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule